// File: doc/BRIEF.md
# Parallel Port with Interrupt Capture

This block is an 8-bit parallel port that sits on the register bus of an embedded controller. Each of the six low bits is either an input or an output, chosen by its own bit in a direction register. An output pin drives the value held in a data register. A read of the port always returns the synchronized pin levels, not the stored data.

The two top bits of the port cannot be driven. They report the live, synchronized levels of two active-low interrupt pins. Each interrupt pin has a mode bit. In edge mode, a falling edge sets a capture latch that holds the interrupt request until software writes a one to that pin's bit of the port. In level mode, the request simply follows the inverted pin level. When an edge arrives in the same cycle as a clear write, the edge wins, so no event is lost.

The bus is a single-cycle write strobe with a 2-bit register address. Reads are combinational from the address. The pad side offers a separate input, output and output-enable per bit, so a tri-state pad cell can be placed outside the block.

Top module: `pport_irq`

## Requirements
- R1: After reset, all six direction bits are 0 (input), `padOe` is 0, the data register (`padOut`) is 0, both mode bits are 0, and `irqReq` is 0 while both interrupt pins are high.
- R2: A write to address 1 loads the direction register from `wdata[5:0]`, where 1 means output. `padOe` equals that register. A read of address 1 returns it in bits 5:0, with bits 7:6 reading 0.
- R3: A write to address 0 loads the data register from `wdata[5:0]`. `padOut` carries the data register from the cycle after the write.
- R4: A read of address 0 returns, in bits 5:0, the level of `padIn` after two synchronizer stages. This holds for every bit whatever its direction; the data register is never returned.
- R5: A read of address 0 returns the synchronized level of `intPinN[1]` in bit 7 and of `intPinN[0]` in bit 6. Bus writes never change these two bits.
- R6: With mode bit i set (address 2, bit 0 for `intPinN[0]`, bit 1 for `intPinN[1]`), a falling edge on `intPinN[i]` sets capture latch i. `irqReq[i]` follows the latch and becomes 1 at the third rising clock edge after the pin falls. The latch stays set after the pin returns high, and a pin held low does not set it again.
- R7: A write to address 0 with `wdata[6]`=1 clears latch 0, and with `wdata[7]`=1 clears latch 1. A zero in either bit leaves that latch unchanged.
- R8: If a capture event and a clear write for the same latch happen in the same cycle, the latch ends set.
- R9: With mode bit i clear, `irqReq[i]` is the inverted level of `intPinN[i]` after two synchronizer stages. It changes at the second rising edge after the pin changes.
- R10: A read of address 2 returns the two mode bits in bits 1:0 and 0 above them. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register address: 0 port, 1 direction, 2 mode, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| padIn | input | 6 | Levels seen at the six general pins |
| padOut | output | 6 | Data register, to the pad drivers |
| padOe | output | 6 | Per-bit output enable, to the pad drivers |
| intPinN | input | 2 | External interrupt pins, active low |
| irqReq | output | 2 | Interrupt requests, active high |

## Verification
The assertions assume that `wrEn` is a single-cycle strobe sampled at the rising edge, and that `padIn` and `intPinN` may change at any time, because they pass through synchronizers before any state uses them. The stimulus changes pins and bus inputs only at falling edges. It holds each pin level for several cycles, except in the race case, where a clear write is placed exactly on the cycle the edge detector fires, so that set-over-clear is tested.

// File: rtl/pport_pkg.sv
package pport_pkg;

  // number of interrupt monitor bits at the top of the port
  localparam int PP_NUM_INT = 2;

  typedef enum logic [1:0] {
    RD_PORT = 2'd0,
    RD_DIR  = 2'd1,
    RD_MODE = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                  dataWr;
    logic                  dirWr;
    logic                  modeWr;
    logic [PP_NUM_INT-1:0] intClr;
    rdSel_e                rdSel;
  } ctrl_t;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int NUM_IO = 6,
  parameter int ADDR_W = 2
) (
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_IO+PP_NUM_INT-1:0] wdata,
  output ctrl_t                        ctrl
);

  localparam int W = NUM_IO + PP_NUM_INT;

  logic isPort;
  logic isDir;
  logic isMode;

  assign isPort = (addr == ADDR_W'(0));
  assign isDir  = (addr == ADDR_W'(1));
  assign isMode = (addr == ADDR_W'(2));

  always_comb begin
    ctrl.dataWr = wrEn && isPort;
    ctrl.dirWr  = wrEn && isDir;
    ctrl.modeWr = wrEn && isMode;
    ctrl.intClr = (wrEn && isPort) ? wdata[W-1 -: PP_NUM_INT] : '0;
    if (isPort)      ctrl.rdSel = RD_PORT;
    else if (isDir)  ctrl.rdSel = RD_DIR;
    else if (isMode) ctrl.rdSel = RD_MODE;
    else             ctrl.rdSel = RD_NONE;
  end

endmodule

// File: rtl/pport_datapath.sv
module pport_datapath
  import pport_pkg::*;
#(
  parameter int NUM_IO      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrl_t                        ctrl,
  input  logic [NUM_IO+PP_NUM_INT-1:0] wdata,
  input  logic [NUM_IO-1:0]            padIn,
  input  logic [PP_NUM_INT-1:0]        intPinN,
  output logic [NUM_IO-1:0]            padOut,
  output logic [NUM_IO-1:0]            padOe,
  output logic [PP_NUM_INT-1:0]        irqReq,
  output logic [NUM_IO+PP_NUM_INT-1:0] rdata
);

  localparam int W = NUM_IO + PP_NUM_INT;

  logic [NUM_IO-1:0]     dataQ;
  logic [NUM_IO-1:0]     dirQ;
  logic [PP_NUM_INT-1:0] modeQ;
  logic [NUM_IO-1:0]     ioLvl;
  logic [PP_NUM_INT-1:0] intLvl;
  logic [PP_NUM_INT-1:0] intPrev;
  logic [PP_NUM_INT-1:0] setEv;
  logic [PP_NUM_INT-1:0] latchQ;

  pport_sync #(.WIDTH(NUM_IO), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_ioSync (
    .clk(clk), .rstN(rstN), .din(padIn), .dout(ioLvl)
  );

  // interrupt pins idle high, so the chain resets high to avoid a false edge
  pport_sync #(.WIDTH(PP_NUM_INT), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_intSync (
    .clk(clk), .rstN(rstN), .din(intPinN), .dout(intLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ   <= '0;
      dirQ    <= '0;
      modeQ   <= '0;
      intPrev <= '1;
    end else begin
      if (ctrl.dataWr) dataQ <= wdata[NUM_IO-1:0];
      if (ctrl.dirWr)  dirQ  <= wdata[NUM_IO-1:0];
      if (ctrl.modeWr) modeQ <= wdata[PP_NUM_INT-1:0];
      intPrev <= intLvl;
    end
  end

  assign padOut = dataQ;
  assign padOe  = dirQ;

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.dirWr |=> $stable(padOe));

  for (genvar i = 0; i < PP_NUM_INT; i++) begin : g_int
    assign setEv[i] = modeQ[i] && intPrev[i] && !intLvl[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                latchQ[i] <= 1'b0;
      else if (setEv[i])        latchQ[i] <= 1'b1;
      else if (ctrl.intClr[i])  latchQ[i] <= 1'b0;
    end

    assign irqReq[i] = modeQ[i] ? latchQ[i] : !intLvl[i];

    // R6
    edge_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      setEv[i] |=> latchQ[i]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (setEv[i] && ctrl.intClr[i]) |=> latchQ[i]);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.intClr[i] && !setEv[i]) |=> !latchQ[i]);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrl.intClr[i] && !setEv[i]) |=> $stable(latchQ[i]));
  end

  always_comb begin
    unique case (ctrl.rdSel)
      RD_PORT: rdata = {intLvl, ioLvl};
      RD_DIR:  rdata = {{PP_NUM_INT{1'b0}}, dirQ};
      RD_MODE: rdata = {{(W-PP_NUM_INT){1'b0}}, modeQ};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/pport_irq.sv
module pport_irq
  import pport_pkg::*;
#(
  parameter int NUM_IO      = 6,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int W          = NUM_IO + PP_NUM_INT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [W-1:0]          wdata,
  output logic [W-1:0]          rdata,
  input  logic [NUM_IO-1:0]     padIn,
  output logic [NUM_IO-1:0]     padOut,
  output logic [NUM_IO-1:0]     padOe,
  input  logic [PP_NUM_INT-1:0] intPinN,
  output logic [PP_NUM_INT-1:0] irqReq
);

  ctrl_t ctrl;

  pport_ctrl #(.NUM_IO(NUM_IO), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .ctrl(ctrl)
  );

  pport_datapath #(.NUM_IO(NUM_IO), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wdata(wdata),
    .padIn(padIn), .intPinN(intPinN),
    .padOut(padOut), .padOe(padOe), .irqReq(irqReq), .rdata(rdata)
  );

endmodule

// File: tb/pport_irq_bench.sv
module pport_irq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_RD  = 0;
  localparam int SEL_OUT = 1;
  localparam int SEL_OE  = 2;
  localparam int SEL_IRQ = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [5:0] padIn = 6'd0;
  logic [5:0] padOut;
  logic [5:0] padOe;
  logic [1:0] intPinN = 2'b11;
  logic [1:0] irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    int         sel;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  pport_irq u_pport_irq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .intPinN(intPinN), .irqReq(irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items shortly after each falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        SEL_RD:  act = rdata;
        SEL_OUT: act = {2'b00, padOut};
        SEL_OE:  act = {2'b00, padOe};
        default: act = {6'b0, irqReq};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectVal(input string tag, input int sel, input logic [7:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    expectVal(tag, SEL_RD, exp);
  endtask

  task automatic irqCheck(input string tag, input logic [1:0] exp);
    @(negedge clk);
    expectVal(tag, SEL_IRQ, {6'b0, exp});
  endtask

  initial begin
    waitCycles(3);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    expectVal("R1 padOe", SEL_OE, 8'h00);
    expectVal("R1 padOut", SEL_OUT, 8'h00);
    expectVal("R1 irqReq", SEL_IRQ, 8'h00);
    readCheck("R1 dir reg", 2'd1, 8'h00);
    readCheck("R1 mode reg", 2'd2, 8'h00);

    // R2 direction register
    busWrite(2'd1, 8'h2A);
    expectVal("R2 padOe", SEL_OE, 8'h2A);
    readCheck("R2 dir read", 2'd1, 8'h2A);
    busWrite(2'd1, 8'hFF);
    readCheck("R2 dir upper bits", 2'd1, 8'h3F);

    // R3 data register
    busWrite(2'd0, 8'h15);
    expectVal("R3 padOut", SEL_OUT, 8'h15);

    // R4 pin readback, not data register
    @(negedge clk); padIn = 6'h0A;
    waitCycles(3);
    readCheck("R4 port read pins", 2'd0, 8'hCA);
    @(negedge clk); padIn = 6'h3F;
    waitCycles(3);
    readCheck("R4 port read pins all", 2'd0, 8'hFF);

    // R5 interrupt pin monitors: bit7 <- intPinN[1], bit6 <- intPinN[0]
    @(negedge clk); padIn = 6'h0A; intPinN = 2'b01;
    waitCycles(3);
    readCheck("R5 bit7 low", 2'd0, 8'h4A);
    busWrite(2'd0, 8'hD5);
    readCheck("R5 write no effect", 2'd0, 8'h4A);
    expectVal("R5 data kept", SEL_OUT, 8'h15);

    // R9 level mode
    irqCheck("R9 level pin2", 2'b10);
    @(negedge clk); intPinN = 2'b00;
    @(negedge clk); expectVal("R9 latency 1", SEL_IRQ, 8'h02);
    @(negedge clk); expectVal("R9 latency 2", SEL_IRQ, 8'h03);
    @(negedge clk); intPinN = 2'b11;
    waitCycles(3);
    irqCheck("R9 released", 2'b00);

    // R10 mode register and unused address
    busWrite(2'd2, 8'hFF);
    readCheck("R10 mode read", 2'd2, 8'h03);
    readCheck("R10 addr3 read", 2'd3, 8'h00);
    irqCheck("R6 no edge yet", 2'b00);

    // R6 edge capture on pin 1
    @(negedge clk); intPinN = 2'b10;
    @(negedge clk); expectVal("R6 before latch", SEL_IRQ, 8'h00);
    @(negedge clk); expectVal("R6 before latch 2", SEL_IRQ, 8'h00);
    @(negedge clk); expectVal("R6 latched", SEL_IRQ, 8'h01);
    intPinN = 2'b11;
    waitCycles(4);
    irqCheck("R6 held after release", 2'b01);

    // R7 clear rules
    busWrite(2'd0, 8'h15);
    irqCheck("R7 zero write no clear", 2'b01);
    busWrite(2'd0, 8'h95);
    irqCheck("R7 other bit no clear", 2'b01);
    busWrite(2'd0, 8'h55);
    irqCheck("R7 clear bit6", 2'b00);

    // R8 set beats clear in same cycle
    @(negedge clk); intPinN = 2'b10;
    @(negedge clk);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd0; wdata = 8'h55;
    @(negedge clk);
    wrEn = 1'b0;
    expectVal("R8 set wins", SEL_IRQ, 8'h01);
    busWrite(2'd0, 8'h55);
    irqCheck("R8 later clear", 2'b00);
    @(negedge clk); intPinN = 2'b11;
    waitCycles(3);

    // R6 pin 2 edge, pin held low does not recapture
    @(negedge clk); intPinN = 2'b01;
    waitCycles(4);
    irqCheck("R6 pin2 latched", 2'b10);
    busWrite(2'd0, 8'h95);
    waitCycles(4);
    irqCheck("R6 held low no recapture", 2'b00);
    readCheck("R5 bit7 live in edge mode", 2'd0, 8'h4A);

    waitCycles(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule